// File: doc/BRIEF.md
# Stereo Serial Audio Output Formatter

This block sits behind a two-channel converter and turns each pair of 16-bit words, left and right, sampled at the same instant, into a serial stream. The stream is carried on three wires: a frame sync, a bit clock and a data line. Every output is registered on the rising edge of one fast sample clock. In master mode the block makes its own bit clock at half the sample-clock rate and its own frame sync. Each frame holds 64 bit periods, which is 128 sample-clock cycles. In slave mode the bit clock and frame sync come from outside. They pass through a synchronizer into the sample-clock domain first, and the block follows the synchronized copies.

A frame has two 32-bit slots: the left word goes in the first slot and the right word in the second. Each word is sent most significant bit first. One control sets where the frame sync falls: either during the first data bit, or during the last bit of the frame before. A justification control places the 16 data bits in the early half or the late half of each slot. A share control releases the data line for the rest of the slot. Two slave devices with opposite justification and share enabled can therefore take turns on one wire.

Top module: `stereo_serial_fmt`

## Requirements
- R1: While `rst_n` is low, at the next rising clock edge `sdo_oe`, `fs_out` and `bck_out` go low, and they stay low until the first bit period starts.
- R2: In master mode (`master_en`=1), `bck_out` toggles on every sample-clock edge. A new bit period starts at each rising edge of `bck_out`, so a bit lasts 2 clock cycles and a frame of 64 bits lasts 128.
- R3: In master mode with `sync_lead`=0, `fs_out` is high only during bit 0 of the frame. With `sync_lead`=1 it is high only during bit 63, the bit just before bit 0.
- R4: Bits 0 to 31 of a frame form the left slot and bits 32 to 63 form the right slot. Within a slot, the word goes out most significant bit first.
- R5: With `late_just`=0, slot positions 0 to 15 carry word bits 15 down to 0. With `late_just`=1, slot positions 16 to 31 carry word bits 15 down to 0.
- R6: With `share_en`=1, `sdo_oe` is high only at the 16 data positions of each slot. With `share_en`=0, `sdo_oe` stays high and `sdo` is 0 at the non-data positions.
- R7: Both words are captured together when bit 0 starts. Changing `left_in` or `right_in` later in the frame does not alter the bits sent in that frame.
- R8: In slave mode (`master_en`=0), `fs_out` and `bck_out` are held low. A bit period starts at each rising edge of `bck_in`, seen after a two-flop synchronizer. If `fs_in` is high at that edge, the bit is bit 0 (`sync_lead`=0) or bit 63 (`sync_lead`=1). Otherwise the bit counter advances by one.
- R9: Two slave instances share one external bit clock and frame sync. One has `late_just`=0 and the other `late_just`=1, and both have `share_en`=1. Their `sdo_oe` outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; every output changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1: generate bit clock and frame sync; 0: follow external ones |
| sync_lead | input | 1 | 1: frame sync one bit ahead of bit 0; 0: frame sync during bit 0 |
| late_just | input | 1 | 1: data in the late half of each slot; 0: early half |
| share_en | input | 1 | 1: release the data line outside the data bits |
| left_in | input | WORD_W | Left-channel word |
| right_in | input | WORD_W | Right-channel word, sampled at the same instant as left |
| fs_in | input | 1 | External frame sync (slave mode) |
| bck_in | input | 1 | External bit clock (slave mode) |
| fs_out | output | 1 | Generated frame sync (master mode), else low |
| bck_out | output | 1 | Generated bit clock (master mode), else low |
| sdo | output | 1 | Serial data, high-impedance while `sdo_oe` is low |
| sdo_oe | output | 1 | Data line drive enable |

## Verification
The bench builds the block with its default sizes: 16-bit words, 32-bit slots and a two-stage synchronizer. At these sizes a frame is only 128 clock cycles, so all eight combinations of sync phase, justification and sharing can be swept in master mode, and every bit position of every frame is compared against values computed by arithmetic. A second instance is then paired with the first in slave mode, with opposite justification, under both sync phases. This checks the shared data line for clean hand-over, and checks that words changed mid-frame never leak into the frame being sent.

// File: rtl/stfmt_pkg.sv
// Shared types for the stereo serial formatter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package stfmt_pkg;

    // Where the frame sync sits relative to bit 0 of a frame.
    typedef enum logic {
        FS_COINCIDENT = 1'b0,
        FS_LEAD       = 1'b1
    } fs_phase_e;

    // Who owns the bit clock and frame sync.
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

endpackage

// File: rtl/stfmt_sync.sv
// Multi-stage synchronizer for a small vector of slow external levels.
// Assumes STAGES >= 2 and inputs that change far slower than clk.
module stfmt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    // Shift the external levels through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-W-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/stfmt_timing.sv
// Bit timing: produces a one-cycle tick at the start of each bit period
// and the index of that bit within the frame. Master mode divides clk by
// two for the bit clock; slave mode follows synchronized external levels.
// Assumes bck_s/fs_s are already in the clk domain.
module stfmt_timing
    import stfmt_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             sync_lead,
    input  logic             bck_s,
    input  logic             fs_s,
    output logic             tick,
    output logic [CNT_W-1:0] nbit,
    output logic             fs_out,
    output logic             bck_out
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    role_e            role;
    fs_phase_e        phase;
    logic [CNT_W-1:0] bitcnt;
    logic [CNT_W-1:0] wrap_next;
    logic [CNT_W-1:0] sync_bit;
    logic             mck;
    logic             bck_prev;
    logic             fs_q;
    logic             bck_q;

    assign role  = role_e'(master_en);
    assign phase = fs_phase_e'(sync_lead);

    // Decide whether a bit starts this cycle and which bit it is.
    always_comb begin
        wrap_next = (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
        sync_bit  = (phase == FS_LEAD) ? LAST_BIT : '0;
        if (role == ROLE_MASTER) begin
            tick = !mck;
            nbit = wrap_next;
        end else begin
            tick = bck_s && !bck_prev;
            nbit = fs_s ? sync_bit : wrap_next;
        end
    end

    // Bit counter, internal half-rate clock and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt   <= LAST_BIT;
            mck      <= 1'b0;
            bck_prev <= 1'b0;
            fs_q     <= 1'b0;
            bck_q    <= 1'b0;
        end else begin
            if (tick) bitcnt <= nbit;
            mck      <= (role == ROLE_MASTER) ? !mck : bck_s;
            bck_prev <= bck_s;
            bck_q    <= (role == ROLE_MASTER) ? !mck : 1'b0;
            if (role != ROLE_MASTER) fs_q <= 1'b0;
            else if (tick)           fs_q <= (nbit == sync_bit);
        end
    end

    assign fs_out  = fs_q;
    assign bck_out = bck_q;

    // R2
    bck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_en && $past(master_en) && $past(master_en, 2) && $past(rst_n)
        |-> bck_out != $past(bck_out));

    // R3
    fs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_en && $past(master_en) && fs_out && $past(fs_out) |=> !fs_out);

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !fs_out && !bck_out);
endmodule

// File: rtl/stfmt_shifter.sv
// Word capture and bit selection: latches both channel words at bit 0 and
// emits one registered data bit and drive enable per bit period.
// Assumes WORD_W <= SLOT_W and nbit valid whenever tick is high.
module stfmt_shifter #(
    parameter int WORD_W = 16,
    parameter int SLOT_W = 32,
    parameter int CNT_W  = $clog2(2 * SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  nbit,
    input  logic              late_just,
    input  logic              share_en,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              sdo_d,
    output logic              sdo_oe
);
    localparam int               IDX_W      = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] SLOT_L     = CNT_W'(SLOT_W);
    localparam logic [CNT_W-1:0] LATE_START = CNT_W'(SLOT_W - WORD_W);

    logic [WORD_W-1:0] hold_l;
    logic [WORD_W-1:0] hold_r;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  pos;
    logic [IDX_W-1:0]  idx;
    logic              right_slot;
    logic              in_data;
    logic              bit_d;
    logic              frame_start;
    logic              sdo_q;
    logic              oe_q;

    // Locate the coming bit inside its slot and pick the word bit.
    always_comb begin
        frame_start = (nbit == '0);
        right_slot  = (nbit >= SLOT_L);
        pos         = right_slot ? nbit - SLOT_L : nbit;
        if (late_just) begin
            in_data = (pos >= LATE_START);
            idx     = IDX_W'(CNT_W'(SLOT_W - 1) - pos);
        end else begin
            in_data = (pos < CNT_W'(WORD_W));
            idx     = IDX_W'(CNT_W'(WORD_W - 1) - pos);
        end
        word  = frame_start ? left_in : (right_slot ? hold_r : hold_l);
        bit_d = in_data && word[idx];
    end

    // Capture both channel words together at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (tick && frame_start) begin
            hold_l <= left_in;
            hold_r <= right_in;
        end
    end

    // Launch the data bit and its drive enable at each bit start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (tick) begin
            sdo_q <= bit_d;
            oe_q  <= in_data || !share_en;
        end
    end

    assign sdo_d  = sdo_q;
    assign sdo_oe = oe_q;

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && nbit == '0) |=> $stable(hold_l) && $stable(hold_r));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo_d);
endmodule

// File: rtl/stereo_serial_fmt.sv
// Top of the stereo serial formatter: synchronizer for the slave inputs,
// bit timing, and word shifter with a tri-state data output.
// Assumes the frame-sync phase is fixed after reset.
module stereo_serial_fmt #(
    parameter int WORD_W      = 16,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              sync_lead,
    input  logic              late_just,
    input  logic              share_en,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    input  logic              fs_in,
    input  logic              bck_in,
    output logic              fs_out,
    output logic              bck_out,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    logic [1:0]       ext_s;
    logic             tick;
    logic [CNT_W-1:0] nbit;
    logic             sdo_d;
    logic             oe;

    stfmt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bck_in, fs_in}),
        .q     (ext_s)
    );

    stfmt_timing #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .sync_lead (sync_lead),
        .bck_s     (ext_s[1]),
        .fs_s      (ext_s[0]),
        .tick      (tick),
        .nbit      (nbit),
        .fs_out    (fs_out),
        .bck_out   (bck_out)
    );

    stfmt_shifter #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .nbit      (nbit),
        .late_just (late_just),
        .share_en  (share_en),
        .left_in   (left_in),
        .right_in  (right_in),
        .sdo_d     (sdo_d),
        .sdo_oe    (oe)
    );

    assign sdo    = oe ? sdo_d : 1'bz;
    assign sdo_oe = oe;
endmodule

// File: tb/sim_stereo_serial_fmt.sv
`timescale 1ns/1ps
module sim_stereo_serial_fmt;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms0 = 1'b1, ld0 = 1'b0, jt0 = 1'b0, sh0 = 1'b0;
    logic ms1 = 1'b0, ld1 = 1'b0, jt1 = 1'b1, sh1 = 1'b1;
    logic [15:0] lw0 = '0, rw0 = '0, lw1 = '0, rw1 = '0;
    logic fs_ext = 1'b0, bck_ext = 1'b0;
    wire  fso0, bco0, sdo0, oe0, fso1, bco1, sdo1, oe1;

    int   n_run = 0, n_fail = 0, ovl_cnt = 0;
    logic bck_last = 1'b0;
    logic watch_slave = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    stereo_serial_fmt u0 (
        .clk(clk), .rst_n(rst_n), .master_en(ms0), .sync_lead(ld0),
        .late_just(jt0), .share_en(sh0), .left_in(lw0), .right_in(rw0),
        .fs_in(fs_ext), .bck_in(bck_ext), .fs_out(fso0), .bck_out(bco0),
        .sdo(sdo0), .sdo_oe(oe0));

    stereo_serial_fmt u1 (
        .clk(clk), .rst_n(rst_n), .master_en(ms1), .sync_lead(ld1),
        .late_just(jt1), .share_en(sh1), .left_in(lw1), .right_in(rw1),
        .fs_in(fs_ext), .bck_in(bck_ext), .fs_out(fso1), .bck_out(bco1),
        .sdo(sdo1), .sdo_oe(oe1));

    // R9: count every cycle in which both slaves drive the shared line
    always @(negedge clk) if (watch_slave && oe0 && oe1) ovl_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 40503 + 32769) ^ (i << 7));
    endfunction

    // Expected bit k of a frame from the requirements R4, R5, R6
    task automatic expect_bit(input int k, input bit just, input bit share,
                              input logic [15:0] L, input logic [15:0] R,
                              output logic d, output logic e);
        int pos = k % 32;
        logic [15:0] w = (k >= 32) ? R : L;
        bit in_d = just ? (pos >= 16) : (pos < 16);
        int idx = just ? 31 - pos : 15 - pos;
        e = in_d || !share;
        d = in_d ? w[idx] : 1'b0;
    endtask

    // Wait for the next rising bck_out, report the bit and cycles waited
    task automatic m_next(output logic d, output logic e, output logic f, output int g);
        logic got = 1'b0;
        g = 0;
        d = 1'b0; e = 1'b0; f = 1'b0;
        while (!got) begin
            @(negedge clk);
            g++;
            if (bco0 && !bck_last) begin
                got = 1'b1;
                d = sdo0; e = oe0; f = fso0;
            end
            bck_last = bco0;
        end
    endtask

    task automatic check_mbit(input int k, input bit lead, input bit just, input bit share,
                              input logic [15:0] L, input logic [15:0] R,
                              input logic d, input logic e, input logic f);
        logic ed, ee;
        expect_bit(k, just, share, L, R, ed, ee);
        chk(e == ee, "R6 output enable", int'(e), int'(ee));
        if (ee) chk(d == ed, "R4 R5 R7 data bit", int'(d), int'(ed));
        chk(f == (lead ? (k == 63) : (k == 0)), "R3 frame sync position", int'(f),
            int'(lead ? (k == 63) : (k == 0)));
    endtask

    task automatic m_frame(input bit lead, input bit just, input bit share,
                           input logic [15:0] L, input logic [15:0] R);
        logic d, e, f;
        int g, total, k;
        lw0 = L; rw0 = R;
        f = 1'b0;
        while (!f) m_next(d, e, f, g);
        if (!lead) begin
            check_mbit(0, lead, just, share, L, R, d, e, f);
            lw0 = ~L; rw0 = R ^ 16'h5A5A;   // R7: late change must not leak
        end
        total = 0;
        for (int j = 1; j <= 64; j++) begin
            m_next(d, e, f, g);
            total += g;
            chk(g == 2, "R2 bit period", g, 2);
            k = lead ? j - 1 : j;
            if (k < 64) begin
                check_mbit(k, lead, just, share, L, R, d, e, f);
                if (lead && k == 0) begin lw0 = ~L; rw0 = R ^ 16'h5A5A; end
            end else begin
                chk(f == 1'b1, "R3 next frame sync", int'(f), 1);
            end
        end
        chk(total == 128, "R2 frame length", total, 128);
    endtask

    // One external bit period of 8 clocks; sample outputs late in the high phase
    task automatic slave_bit(input logic f, output logic o0, output logic d0,
                             output logic o1, output logic d1, output logic quiet);
        @(negedge clk);
        bck_ext = 1'b1; fs_ext = f;
        repeat (3) @(negedge clk);
        o0 = oe0; d0 = sdo0; o1 = oe1; d1 = sdo1;
        quiet = !fso0 && !bco0 && !fso1 && !bco1;
        @(negedge clk);
        bck_ext = 1'b0; fs_ext = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic s_frames(input bit lead);
        logic o0, d0, o1, d1, quiet, line, ed;
        logic [15:0] a0, b0, a1, b1;
        int pos;
        if (lead) slave_bit(1'b1, o0, d0, o1, d1, quiet);
        for (int fr = 0; fr < 3; fr++) begin
            a0 = pat(fr + 20); b0 = pat(fr + 40); a1 = pat(fr + 60); b1 = pat(fr + 80);
            lw0 = a0; rw0 = b0; lw1 = a1; rw1 = b1;
            for (int k = 0; k < 64; k++) begin
                slave_bit(lead ? (k == 63) : (k == 0), o0, d0, o1, d1, quiet);
                pos = k % 32;
                chk(o0 == (pos < 16), "R9 early instance enable", int'(o0), int'(pos < 16));
                chk(o1 == (pos >= 16), "R9 late instance enable", int'(o1), int'(pos >= 16));
                line = o0 ? d0 : d1;
                if (pos < 16) ed = (k >= 32) ? b0[15 - pos] : a0[15 - pos];
                else          ed = (k >= 32) ? b1[31 - pos] : a1[31 - pos];
                chk(line == ed, "R8 slave data bit", int'(line), int'(ed));
                chk(quiet, "R8 slave clock outputs low", int'(!quiet), 0);
                if (k == 0) begin
                    lw0 = ~a0; rw0 = ~b0; lw1 = ~a1; rw1 = ~b1;   // R7
                end
            end
        end
    endtask

    initial begin
        // Master sweep over all phase, justification and share settings
        for (int cfg = 0; cfg < 8; cfg++) begin
            @(negedge clk);
            rst_n = 1'b0;
            ms0 = 1'b1; ld0 = cfg[0]; jt0 = cfg[1]; sh0 = cfg[2];
            repeat (3) @(negedge clk);
            chk(!oe0 && !fso0 && !bco0, "R1 reset outputs low",
                int'({oe0, fso0, bco0}), 0);
            bck_last = 1'b0;
            rst_n = 1'b1;
            for (int fr = 0; fr < 2; fr++)
                m_frame(cfg[0], cfg[1], cfg[2], pat(cfg * 4 + fr), ~pat(cfg * 4 + fr + 2));
        end
        // Slave pair sharing one line, both sync phases
        for (int lead = 0; lead < 2; lead++) begin
            @(negedge clk);
            rst_n = 1'b0;
            ms0 = 1'b0; ms1 = 1'b0; sh0 = 1'b1; sh1 = 1'b1;
            jt0 = 1'b0; jt1 = 1'b1; ld0 = lead[0]; ld1 = lead[0];
            bck_ext = 1'b0; fs_ext = 1'b0;
            repeat (3) @(negedge clk);
            chk(!oe0 && !oe1, "R1 reset enables low", int'({oe0, oe1}), 0);
            rst_n = 1'b1;
            watch_slave = 1'b1;
            s_frames(lead[0]);
            watch_slave = 1'b0;
        end
        chk(ovl_cnt == 0, "R9 no overlapping drive", ovl_cnt, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule